// File: doc/BRIEF.md
# Four-Channel Conversion Sequencer

This block decides when a four-input sampling converter starts a conversion and which input that conversion samples. A start is requested by pulling the active-low select and the active-low read/convert request low while the block is idle. Each accepted start produces a one-cycle start pulse. It then holds the busy flag low for a fixed number of clock cycles, which stand in for the analog conversion time. Busy returns high together with a one-cycle done pulse.

The block has two channel modes. In manual mode the two address inputs are captured when a conversion starts, but they take effect only for the following conversion. Each conversion therefore samples the address that was captured one start earlier. In scan mode the block starts conversions back to back while select, request and sleep are all low, and it steps through the inputs in order. The address pins become outputs that show the next channel to be sampled. The sleep input powers the converter down. A result whose conversion overlapped sleep is flagged invalid, and in scan mode sleep sends the sequence back to input 0.

Top module: `conv_sequencer`

## Requirements
- R1: After reset, busy is 1, start_pulse and done_pulse are 0, addr_oe is 0 while scan_mode is 0, and the channel used by the first conversion is 0.
- R2: A start is accepted at a rising edge when busy is 1, sel_n is 0 and rdconv_n is 0. In scan mode sleep must also be 0. In the cycle after that edge, start_pulse is 1 and busy is 0. Busy then stays 0 for exactly CONV_CYCLES cycles and returns to 1 in the same cycle that done_pulse is 1 for one cycle.
- R3: While busy is 0, a convert request is ignored. No start_pulse appears, the busy length is unchanged, and an address presented then is not captured.
- R4: In manual mode (scan_mode 0), active_chan for a conversion equals the addr_in value sampled at the previous accepted start, or 0 if there was none. addr_in is an unsigned binary channel number.
- R5: In scan mode, conversions restart with one idle cycle between them, and active_chan follows 0, 1, 2, 3 and wraps from 3 to 0.
- R6: addr_oe equals scan_mode. In scan mode, addr_out shows the next channel, and it increments in the same cycle that busy returns to 1.
- R7: In scan mode, a cycle with sleep at 1 sets the next channel to 0, and it also blocks new starts. The conversion that sleep overlapped still completes.
- R8: In scan mode, once the start conditions drop, no new conversion starts. A later restart uses the channel that follows the last one converted.
- R9: done_invalid is 1 together with done_pulse exactly when sleep was 1 in any cycle from the start edge through the end edge of that conversion. A manual start with sleep at 1 is still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scan_mode | input | 1 | 1 selects scan mode, 0 selects manual mode |
| sel_n | input | 1 | Device select, active low |
| rdconv_n | input | 1 | Convert request when low |
| sleep | input | 1 | Power-down request |
| addr_in | input | 2 | Manual channel address for the next conversion |
| busy | output | 1 | 1 when idle, 0 during a conversion |
| start_pulse | output | 1 | One-cycle pulse when a conversion begins |
| active_chan | output | 2 | Channel of the current or last conversion |
| addr_out | output | 2 | Next channel, driven on the address pins in scan mode |
| addr_oe | output | 1 | Address pin output enable |
| done_pulse | output | 1 | One-cycle pulse when a conversion ends |
| done_invalid | output | 1 | Result flagged as meaningless, valid with done_pulse |

## Verification
Manual mode is driven with a run of different addresses, so that a design using the same-start address can be told apart from one that uses the address captured one start earlier. The manual runs also include a convert request and a new address presented during busy, which separates ignoring that request from re-latching on it. Sleep is applied in three ways: only at the start edge, only in the middle of a conversion, and held high across the end in scan mode. These separate invalid tracking over the whole window from tracking at one edge. Scan mode runs through a wrap of the channel sequence, then a pause and a restart, which tells continuing from the next channel apart from resetting to channel 0.

// File: rtl/convseq_pkg.sv
package convseq_pkg;
   // address width for a given channel count
   function automatic int unsigned chan_bits(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction
endpackage

// File: rtl/conv_timer.sv
module conv_timer #(
   parameter int unsigned CONV_CYCLES = 5
) (
   input  logic clk,
   input  logic rst_n,
   input  logic launch,
   output logic idle,
   output logic ending,
   output logic finish
);
   if (CONV_CYCLES < 1) begin : g_bad_len
      $error("conv_timer: CONV_CYCLES must be at least 1");
   end

   if (CONV_CYCLES == 1) begin : g_single
      assign ending = !idle;
   end else begin : g_count
      localparam int unsigned CW = $clog2(CONV_CYCLES);
      localparam logic [CW-1:0] LOAD = CW'(CONV_CYCLES - 1);
      logic [CW-1:0] remain;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)          remain <= '0;
         else if (launch)     remain <= LOAD;
         else if (!idle && remain != '0) remain <= remain - 1'b1;
      end
      assign ending = !idle && (remain == '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle   <= 1'b1;
         finish <= 1'b0;
      end else begin
         finish <= ending;
         if (launch)      idle <= 1'b0;
         else if (ending) idle <= 1'b1;
      end
   end

   assert_launch_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
      launch |=> !idle);
   assert_finish_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
      finish |-> (idle && !$past(idle)));
endmodule

// File: rtl/chan_tracker.sv
module chan_tracker #(
   parameter int unsigned NUM_CH = 4,
   localparam int unsigned AW = convseq_pkg::chan_bits(NUM_CH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scan,
   input  logic          sleep,
   input  logic          launch,
   input  logic          ending,
   input  logic [AW-1:0] addr_in,
   output logic [AW-1:0] active_ch,
   output logic [AW-1:0] next_ch
);
   if (NUM_CH < 2 || (1 << AW) != NUM_CH) begin : g_bad_count
      $error("chan_tracker: NUM_CH must be a power of two, at least 2");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active_ch <= '0;
         next_ch   <= '0;
      end else begin
         if (launch) active_ch <= next_ch;
         if (!scan) begin
            if (launch) next_ch <= addr_in;
         end else if (sleep) begin
            next_ch <= '0;
         end else if (ending) begin
            next_ch <= next_ch + AW'(1);
         end
      end
   end

   assert_manual_pipe_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (launch && !scan) |=> (active_ch == $past(next_ch)));
   assert_scan_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (scan && ending && !sleep && !launch) |=> (next_ch == active_ch + AW'(1)));
   assert_sleep_home_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (scan && sleep) |=> (next_ch == '0));
endmodule

// File: rtl/conv_sequencer.sv
module conv_sequencer #(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned CONV_CYCLES = 5,
   localparam int unsigned AW = convseq_pkg::chan_bits(NUM_CH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          scan_mode,
   input  logic          sel_n,
   input  logic          rdconv_n,
   input  logic          sleep,
   input  logic [AW-1:0] addr_in,
   output logic          busy,
   output logic          start_pulse,
   output logic [AW-1:0] active_chan,
   output logic [AW-1:0] addr_out,
   output logic          addr_oe,
   output logic          done_pulse,
   output logic          done_invalid
);
   logic go, ending, spoiled;

   // scan mode refuses to start while asleep; manual start proceeds (flagged)
   assign go = busy && !sel_n && !rdconv_n && !(scan_mode && sleep);

   conv_timer #(.CONV_CYCLES(CONV_CYCLES)) u_timer (
      .clk(clk), .rst_n(rst_n), .launch(go),
      .idle(busy), .ending(ending), .finish(done_pulse)
   );

   chan_tracker #(.NUM_CH(NUM_CH)) u_chan (
      .clk(clk), .rst_n(rst_n), .scan(scan_mode), .sleep(sleep),
      .launch(go), .ending(ending), .addr_in(addr_in),
      .active_ch(active_chan), .next_ch(addr_out)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_pulse  <= 1'b0;
         spoiled      <= 1'b0;
         done_invalid <= 1'b0;
      end else begin
         start_pulse  <= go;
         done_invalid <= ending && (spoiled || sleep);
         if (go)         spoiled <= sleep;
         else if (!busy) spoiled <= spoiled || sleep;
      end
   end

   assign addr_oe = scan_mode;

   assert_ignore_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |=> !start_pulse);
   assert_inv_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done_invalid |-> done_pulse);
   assert_sleep_mark_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && sleep && !done_pulse) |=> (spoiled || done_pulse));
endmodule

// File: tb/conv_sequencer_test.sv
module conv_sequencer_test;
   localparam int N = 5;
   logic clk = 1'b0, rst_n = 1'b0;
   logic scan_mode = 1'b0, sel_n = 1'b1, rdconv_n = 1'b1, sleep = 1'b0;
   logic [1:0] addr_in = 2'd0;
   logic busy, start_pulse, addr_oe, done_pulse, done_invalid;
   logic [1:0] active_chan, addr_out;

   typedef struct { logic [1:0] ch; logic inv; string tag; } exp_t;
   exp_t q[$];
   int nchk = 0, nerr = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   conv_sequencer #(.NUM_CH(4), .CONV_CYCLES(N)) uut (
      .clk(clk), .rst_n(rst_n), .scan_mode(scan_mode), .sel_n(sel_n),
      .rdconv_n(rdconv_n), .sleep(sleep), .addr_in(addr_in), .busy(busy),
      .start_pulse(start_pulse), .active_chan(active_chan), .addr_out(addr_out),
      .addr_oe(addr_oe), .done_pulse(done_pulse), .done_invalid(done_invalid)
   );

   task automatic chk(input string tag, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nerr++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic push(input logic [1:0] ch, input logic inv, input string tag);
      exp_t e;
      e.ch = ch; e.inv = inv; e.tag = tag;
      q.push_back(e);
   endtask

   // monitor: scoreboard compare on every done pulse
   always @(negedge clk) begin
      if (rst_n && done_pulse) begin
         if (q.size() == 0) chk("R2 unexpected done", 1, 0);
         else begin
            exp_t e;
            e = q.pop_front();
            chk({e.tag, " channel"}, active_chan, e.ch);
            chk("R9 invalid flag", done_invalid, e.inv);
         end
      end
   end

   task automatic wait_done();
      do @(negedge clk); while (!done_pulse);
   endtask

   // one manual conversion; optional sleep at start / mid, optional ignored request
   task automatic man_conv(input logic [1:0] a, input logic slp_start, input logic slp_mid,
                           input bit ign, input logic [1:0] ech, input logic einv,
                           input string tag);
      int len;
      push(ech, einv, tag);
      @(negedge clk);
      sel_n = 0; rdconv_n = 0; addr_in = a; sleep = slp_start;
      @(negedge clk);
      chk("R2 start pulse", start_pulse, 1);
      chk("R2 busy low", busy, 0);
      rdconv_n = 1; sleep = slp_mid;
      len = 1;
      forever begin
         @(negedge clk);
         sleep = 0;
         if (busy) break;
         len++;
         chk(ign ? "R3 no restart" : "R2 single start", start_pulse, 0);
         if (ign && len == 2) begin rdconv_n = 0; addr_in = 2'd3; end
         if (ign && len == 3) rdconv_n = 1;
      end
      chk(ign ? "R3 busy length" : "R2 busy length", len, N);
      chk("R2 done with busy rise", done_pulse, 1);
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      if (!finished) begin
         nerr++; nchk++;
         $display("FAIL watchdog actual=0 expected=1");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy", busy, 1);
      chk("R1 start_pulse", start_pulse, 0);
      chk("R1 done_pulse", done_pulse, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 addr_oe", addr_oe, 0);

      // manual mode: one-start pipeline on the address
      man_conv(2'd2, 0, 0, 0, 2'd0, 0, "R1 R4");
      man_conv(2'd1, 0, 0, 0, 2'd2, 0, "R4");
      man_conv(2'd3, 1, 0, 0, 2'd1, 1, "R4 R9");
      man_conv(2'd0, 0, 1, 0, 2'd3, 1, "R4 R9");
      man_conv(2'd1, 0, 0, 1, 2'd0, 0, "R3");
      man_conv(2'd2, 0, 0, 0, 2'd1, 0, "R3 R4");
      sel_n = 1;

      // scan mode
      @(negedge clk);
      scan_mode = 1; sel_n = 0; rdconv_n = 1;
      @(negedge clk);
      chk("R6 addr_oe", addr_oe, 1);
      chk("R6 addr_out", addr_out, 2);
      sleep = 1; rdconv_n = 0;
      @(negedge clk);
      chk("R7 next to zero", addr_out, 0);
      @(negedge clk);
      chk("R7 no start asleep", busy, 1);
      chk("R7 no start pulse", start_pulse, 0);
      for (int i = 0; i < 6; i++) push(2'(i % 4), 0, "R5");
      sleep = 0;
      for (int i = 0; i < 6; i++) begin
         wait_done();
         chk("R6 addr_out step", addr_out, (i + 1) % 4);
         if (i < 5) begin
            @(negedge clk);
            chk("R5 back to back", start_pulse, 1);
         end else rdconv_n = 1;
      end
      repeat (4) begin
         @(negedge clk);
         chk("R8 stopped", busy, 1);
      end
      chk("R8 next held", addr_out, 2);
      push(2'd2, 0, "R8");
      rdconv_n = 0;
      wait_done();
      rdconv_n = 1;
      chk("R8 next after restart", addr_out, 3);

      // sleep during a scan conversion
      push(2'd3, 1, "R7");
      rdconv_n = 0;
      @(negedge clk);
      sleep = 1;
      wait_done();
      chk("R7 reset on sleep", addr_out, 0);
      @(negedge clk);
      chk("R7 blocked", busy, 1);
      push(2'd0, 0, "R7");
      sleep = 0;
      wait_done();
      rdconv_n = 1;

      @(negedge clk);
      scan_mode = 0;
      @(negedge clk);
      chk("R6 addr_oe off", addr_oe, 0);
      repeat (3) @(negedge clk);
      chk("R2 all results seen", q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end
endmodule